// File: doc/BRIEF.md
# RF Front-End Operating State Controller

This block sequences the operating states of a radio front-end: powered off, configuration, receive, transmit and a key-guarded fuse-programming state. It takes the active-high supply-enable pin, receive and transmit requests from pins and from register bits, an arm bit with a key write for the fuse state, and an antenna select pin. It drives the receive amplifier enable, the transmit amplifier enable and the two antenna switch enables. It also drives a one-cycle pulse that tells the register file to return to its reset values, and a flag that reports when the analog path has settled after the last state change.

Each state change has its own settling budget, given in nanoseconds. The budget is converted to clock cycles from a clock-rate parameter. The settled flag falls on every state change and rises again once the budget for that change has run out. If receive and transmit are requested at the same time, the controller stays in, or falls back to, the configuration state and raises a conflict flag. Both amplifiers are therefore never enabled together.

Top module: `rffe_state_ctrl`

## Requirements
- R1: During and after reset, `rf_state` reads 0 (off), all four enables and `regs_clr` are 0, `settled` is 1 and `req_conflict` is 0. The state codes are 0 = off, 1 = configuration, 2 = receive, 3 = transmit, 4 = fuse.
- R2: On the first clock edge at which `pwr_on` is 0, the state becomes off, whatever the state was. On the first edge at which `pwr_on` is 1 while the state is off, the state becomes configuration.
- R3: `regs_clr` is 1 for exactly the one cycle that follows an off-to-configuration change, and 0 at all other times.
- R4: In configuration, a receive request (`rx_pin` OR `rx_bit`) moves to receive with `lna_en`=1, and a transmit request (`tx_pin` OR `tx_bit`) moves to transmit with `pa_en`=1. When the active request drops, the state returns to configuration.
- R5: When both requests are active, configuration is held (or, from receive or transmit, returned to) and `req_conflict` is 1 one edge later. `req_conflict` goes back to 0 once the conflict ends. `lna_en` and `pa_en` are never 1 together.
- R6: Fuse is entered only from configuration, on an edge where `key_wr`=1, `key_val`=4'hF and `fuse_arm`=1. A key write with any other value, with `fuse_arm`=0, or while in receive or transmit, leaves the state unchanged.
- R7: In fuse, a key write of 4'h0 returns to configuration. Receive and transmit requests, and other key values, are ignored in fuse.
- R8: Both antenna enables are 0 in off, configuration and fuse. In receive and transmit, `ant_sel`=0 gives `ant1_en`=1 only, and `ant_sel`=1 gives `ant2_en`=1 only.
- R9: `settled` is 0 from the edge at which the state changes until exactly N edges later, when it becomes 1. N = ceil(T_ns × CLK_MHZ / 1000), where T_ns is 17500 for off to configuration, 10500 for configuration to receive or transmit, 3000 for receive or transmit to configuration, 10000 for any change into off, and 1000 for a change into or out of fuse. A new state change restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Supply-enable pin; 0 forces the off state |
| rx_pin | input | 1 | Receive request from a pin |
| tx_pin | input | 1 | Transmit request from a pin |
| rx_bit | input | 1 | Receive request from a register bit |
| tx_bit | input | 1 | Transmit request from a register bit |
| fuse_arm | input | 1 | Fuse-state arm bit |
| key_wr | input | 1 | Key field written this cycle |
| key_val | input | 4 | Key value written |
| ant_sel | input | 1 | Antenna select pin |
| rf_state | output | 3 | Current state code |
| lna_en | output | 1 | Receive amplifier enable |
| pa_en | output | 1 | Transmit amplifier enable |
| ant1_en | output | 1 | Antenna 1 switch enable |
| ant2_en | output | 1 | Antenna 2 switch enable |
| regs_clr | output | 1 | One-cycle register reset pulse |
| settled | output | 1 | Settling time for the last change has elapsed |
| req_conflict | output | 1 | Receive and transmit requested together |

## Verification
A wrong state register shows on `rf_state` and on the amplifier and antenna enables at the first negative edge after the faulty clock edge. No state change is hidden behind a delay. A wrongly chosen settling class, or an off-by-one count, shows only at the end of the window, so each window is sampled one cycle before and at its expected end. Ignored stimuli (bad keys, an unarmed key write, requests during fuse) are checked by observing on the next cycle that the state code and enables have not moved.

// File: rtl/rffe_pkg.sv
package rffe_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_CFG  = 3'd1,
        ST_RX   = 3'd2,
        ST_TX   = 3'd3,
        ST_FUSE = 3'd4
    } rffe_state_e;

    typedef enum logic [2:0] {
        SC_WAKE     = 3'd0,
        SC_PATH_ON  = 3'd1,
        SC_PATH_OFF = 3'd2,
        SC_SLEEP    = 3'd3,
        SC_FUSE     = 3'd4
    } settle_cls_e;

    typedef struct packed {
        rffe_state_e st;
        logic        conflict;
        logic        clr;
    } fsm_reg_t;

    // Convert a time budget in ns to whole clock cycles, rounded up, minimum 1.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned mhz);
        int unsigned c;
        c = (t_ns * mhz + 999) / 1000;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/rffe_req_merge.sv
module rffe_req_merge (
    input  logic rx_pin,
    input  logic rx_bit,
    input  logic tx_pin,
    input  logic tx_bit,
    output logic rx_req,
    output logic tx_req,
    output logic both_req
);
    always_comb begin
        rx_req   = rx_pin | rx_bit;
        tx_req   = tx_pin | tx_bit;
        both_req = rx_req & tx_req;
    end
endmodule

// File: rtl/rffe_settle_timer.sv
module rffe_settle_timer
    import rffe_pkg::*;
#(
    parameter int unsigned CYC_WAKE     = 175,
    parameter int unsigned CYC_PATH_ON  = 105,
    parameter int unsigned CYC_PATH_OFF = 30,
    parameter int unsigned CYC_SLEEP    = 100,
    parameter int unsigned CYC_FUSE     = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  settle_cls_e cls,
    output logic        settled
);
    localparam int unsigned MAX_A   = (CYC_WAKE > CYC_PATH_ON) ? CYC_WAKE : CYC_PATH_ON;
    localparam int unsigned MAX_B   = (CYC_PATH_OFF > CYC_SLEEP) ? CYC_PATH_OFF : CYC_SLEEP;
    localparam int unsigned MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CYC_MAX = (MAX_AB > CYC_FUSE) ? MAX_AB : CYC_FUSE;
    localparam int          CW      = $clog2(CYC_MAX + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t          tmr_d, tmr_q;
    logic [CW-1:0] lim;

    always_comb begin
        case (cls)
            SC_WAKE:     lim = CW'(CYC_WAKE - 1);
            SC_PATH_ON:  lim = CW'(CYC_PATH_ON - 1);
            SC_PATH_OFF: lim = CW'(CYC_PATH_OFF - 1);
            SC_SLEEP:    lim = CW'(CYC_SLEEP - 1);
            default:     lim = CW'(CYC_FUSE - 1);
        endcase
    end

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = lim;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign settled = ~tmr_q.busy;

endmodule

// File: rtl/rffe_path_decode.sv
module rffe_path_decode
    import rffe_pkg::*;
(
    input  rffe_state_e st,
    input  logic        ant_sel,
    output logic        lna_en,
    output logic        pa_en,
    output logic        ant1_en,
    output logic        ant2_en
);
    logic path_live;

    always_comb begin
        lna_en    = (st == ST_RX);
        pa_en     = (st == ST_TX);
        path_live = lna_en | pa_en;
        ant1_en   = path_live & ~ant_sel;
        ant2_en   = path_live &  ant_sel;
    end
endmodule

// File: rtl/rffe_state_ctrl.sv
module rffe_state_ctrl
    import rffe_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 10,
    parameter int unsigned WAKE_NS     = 17500,
    parameter int unsigned PATH_ON_NS  = 10500,
    parameter int unsigned PATH_OFF_NS = 3000,
    parameter int unsigned SLEEP_NS    = 10000,
    parameter int unsigned FUSE_NS     = 1000,
    parameter int unsigned KEY_W       = 4,
    parameter logic [KEY_W-1:0] KEY_OPEN  = '1,
    parameter logic [KEY_W-1:0] KEY_CLOSE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             rx_pin,
    input  logic             tx_pin,
    input  logic             rx_bit,
    input  logic             tx_bit,
    input  logic             fuse_arm,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             ant_sel,
    output logic [2:0]       rf_state,
    output logic             lna_en,
    output logic             pa_en,
    output logic             ant1_en,
    output logic             ant2_en,
    output logic             regs_clr,
    output logic             settled,
    output logic             req_conflict
);
    localparam int unsigned CYC_WAKE     = ns_to_cyc(WAKE_NS, CLK_MHZ);
    localparam int unsigned CYC_PATH_ON  = ns_to_cyc(PATH_ON_NS, CLK_MHZ);
    localparam int unsigned CYC_PATH_OFF = ns_to_cyc(PATH_OFF_NS, CLK_MHZ);
    localparam int unsigned CYC_SLEEP    = ns_to_cyc(SLEEP_NS, CLK_MHZ);
    localparam int unsigned CYC_FUSE     = ns_to_cyc(FUSE_NS, CLK_MHZ);

    logic        rx_req, tx_req, both_req;
    logic        key_open, key_close;
    logic        moved;
    settle_cls_e cls;
    fsm_reg_t    fsm_d, fsm_q;

    rffe_req_merge u_req (
        .rx_pin   (rx_pin),
        .rx_bit   (rx_bit),
        .tx_pin   (tx_pin),
        .tx_bit   (tx_bit),
        .rx_req   (rx_req),
        .tx_req   (tx_req),
        .both_req (both_req)
    );

    assign key_open  = key_wr & fuse_arm & (key_val == KEY_OPEN);
    assign key_close = key_wr & (key_val == KEY_CLOSE);

    // Next-state computation
    always_comb begin
        fsm_d          = fsm_q;
        fsm_d.clr      = 1'b0;
        fsm_d.conflict = 1'b0;
        if (!pwr_on) begin
            fsm_d.st = ST_OFF;
        end else begin
            case (fsm_q.st)
                ST_OFF: begin
                    fsm_d.st  = ST_CFG;
                    fsm_d.clr = 1'b1;
                end
                ST_CFG: begin
                    if (both_req)      fsm_d.conflict = 1'b1;
                    else if (rx_req)   fsm_d.st = ST_RX;
                    else if (tx_req)   fsm_d.st = ST_TX;
                    else if (key_open) fsm_d.st = ST_FUSE;
                end
                ST_RX: begin
                    fsm_d.conflict = both_req;
                    if (both_req || !rx_req) fsm_d.st = ST_CFG;
                end
                ST_TX: begin
                    fsm_d.conflict = both_req;
                    if (both_req || !tx_req) fsm_d.st = ST_CFG;
                end
                ST_FUSE: begin
                    if (key_close) fsm_d.st = ST_CFG;
                end
                default: fsm_d.st = ST_OFF;
            endcase
        end
    end

    // Settling class of the change about to happen
    always_comb begin
        moved = (fsm_d.st != fsm_q.st);
        if (fsm_d.st == ST_OFF)
            cls = SC_SLEEP;
        else if (fsm_q.st == ST_OFF)
            cls = SC_WAKE;
        else if (fsm_d.st == ST_FUSE || fsm_q.st == ST_FUSE)
            cls = SC_FUSE;
        else if (fsm_d.st == ST_RX || fsm_d.st == ST_TX)
            cls = SC_PATH_ON;
        else
            cls = SC_PATH_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st       <= ST_OFF;
            fsm_q.conflict <= 1'b0;
            fsm_q.clr      <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    rffe_settle_timer #(
        .CYC_WAKE     (CYC_WAKE),
        .CYC_PATH_ON  (CYC_PATH_ON),
        .CYC_PATH_OFF (CYC_PATH_OFF),
        .CYC_SLEEP    (CYC_SLEEP),
        .CYC_FUSE     (CYC_FUSE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (moved),
        .cls     (cls),
        .settled (settled)
    );

    rffe_path_decode u_path (
        .st      (fsm_q.st),
        .ant_sel (ant_sel),
        .lna_en  (lna_en),
        .pa_en   (pa_en),
        .ant1_en (ant1_en),
        .ant2_en (ant2_en)
    );

    assign rf_state     = fsm_q.st;
    assign regs_clr     = fsm_q.clr;
    assign req_conflict = fsm_q.conflict;

endmodule

// File: rtl/rffe_state_ctrl_chk.sv
module rffe_state_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_on,
    input logic [2:0] rf_state,
    input logic       lna_en,
    input logic       pa_en,
    input logic       ant1_en,
    input logic       ant2_en,
    input logic       regs_clr,
    input logic       settled
);
    // R5
    no_dual_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lna_en && pa_en));

    // R8
    ant_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lna_en && !pa_en) |-> (!ant1_en && !ant2_en));

    // R8
    ant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lna_en || pa_en) |-> $onehot({ant1_en, ant2_en}));

    // R2
    pwr_force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (rf_state == 3'd0));

    // R3
    clr_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_clr |-> ($past(rf_state) == 3'd0 && rf_state == 3'd1));

    // R9
    settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_state != $past(rf_state)) |-> !settled);

    // R6
    fuse_from_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_state == 3'd4 && $past(rf_state) != 3'd4) |-> ($past(rf_state) == 3'd1));

endmodule

bind rffe_state_ctrl rffe_state_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_on   (pwr_on),
    .rf_state (rf_state),
    .lna_en   (lna_en),
    .pa_en    (pa_en),
    .ant1_en  (ant1_en),
    .ant2_en  (ant2_en),
    .regs_clr (regs_clr),
    .settled  (settled)
);

// File: tb/rffe_state_ctrl_tb.sv
module rffe_state_ctrl_tb;

    localparam int N_WAKE = 175;  // 17500 ns at 10 cycles/us
    localparam int N_ON   = 105;
    localparam int N_OFF  = 30;
    localparam int N_SLP  = 100;
    localparam int N_FUSE = 10;

    localparam logic [2:0] S_OFF = 3'd0, S_CFG = 3'd1, S_RX = 3'd2, S_TX = 3'd3, S_FUSE = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on = 0, rx_pin = 0, tx_pin = 0, rx_bit = 0, tx_bit = 0;
    logic       fuse_arm = 0, key_wr = 0, ant_sel = 0;
    logic [3:0] key_val = 4'h0;
    logic [2:0] rf_state;
    logic       lna_en, pa_en, ant1_en, ant2_en, regs_clr, settled, req_conflict;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rffe_state_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
        .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_bit(rx_bit), .tx_bit(tx_bit),
        .fuse_arm(fuse_arm), .key_wr(key_wr), .key_val(key_val), .ant_sel(ant_sel),
        .rf_state(rf_state), .lna_en(lna_en), .pa_en(pa_en),
        .ant1_en(ant1_en), .ant2_en(ant2_en), .regs_clr(regs_clr),
        .settled(settled), .req_conflict(req_conflict)
    );

    typedef struct {
        logic [9:0] vec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event smp;

    // Expected port vector: {state, lna, pa, ant1, ant2, clr, settled, conflict}
    function automatic logic [9:0] mk(input logic [2:0] st, input logic sel,
                                      input logic stl, input logic clr, input logic cf);
        logic live;
        live = (st == S_RX) || (st == S_TX);
        return {st, st == S_RX, st == S_TX, live & ~sel, live & sel, clr, stl, cf};
    endfunction

    task automatic expect_now(input logic [2:0] st, input logic stl, input logic clr,
                              input logic cf, input string tag);
        exp_t e;
        e.vec = mk(st, ant_sel, stl, clr, cf);
        e.tag = tag;
        exp_q.push_back(e);
        ->smp;
        #1;
    endtask

    // Monitor: pops each expected item and compares it with the ports
    initial begin
        forever begin
            exp_t e;
            logic [9:0] act;
            @(smp);
            e = exp_q.pop_front();
            act = {rf_state, lna_en, pa_en, ant1_en, ant2_en, regs_clr, settled, req_conflict};
            checks++;
            if (act !== e.vec) begin
                errors++;
                $display("FAIL %s: actual %b expected %b", e.tag, act, e.vec);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    // Called at the negedge just after a transition edge
    task automatic settle_chk(input logic [2:0] st, input int n, input string tag);
        repeat (n - 1) @(negedge clk);
        expect_now(st, 1'b0, 1'b0, 1'b0, tag);
        @(negedge clk);
        expect_now(st, 1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_now(S_OFF, 1'b1, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        step();
        expect_now(S_OFF, 1'b1, 1'b0, 1'b0, "R1 after reset");

        // Wake
        pwr_on = 1'b1;
        step();
        expect_now(S_CFG, 1'b0, 1'b1, 1'b0, "R2 R3 wake with clear pulse");
        settle_chk(S_CFG, N_WAKE, "R9 wake window R3 pulse gone");

        // Receive via pin, antenna 1 then 2
        rx_pin = 1'b1; ant_sel = 1'b0;
        step();
        expect_now(S_RX, 1'b0, 1'b0, 1'b0, "R4 R8 enter receive ant1");
        settle_chk(S_RX, N_ON, "R9 path-on window");
        ant_sel = 1'b1;
        #1;
        expect_now(S_RX, 1'b1, 1'b0, 1'b0, "R8 receive ant2");
        step();
        rx_pin = 1'b0;
        step();
        expect_now(S_CFG, 1'b0, 1'b0, 1'b0, "R4 leave receive");
        settle_chk(S_CFG, N_OFF, "R9 path-off window");

        // Transmit via bit
        tx_bit = 1'b1; ant_sel = 1'b0;
        step();
        expect_now(S_TX, 1'b0, 1'b0, 1'b0, "R4 R8 enter transmit ant1");
        settle_chk(S_TX, N_ON, "R9 transmit window");

        // Conflict
        rx_pin = 1'b1;
        step();
        expect_now(S_CFG, 1'b0, 1'b0, 1'b1, "R5 conflict drops to config");
        step();
        expect_now(S_CFG, 1'b0, 1'b0, 1'b1, "R5 conflict holds config");
        rx_pin = 1'b0;
        step();
        expect_now(S_TX, 1'b0, 1'b0, 1'b0, "R5 conflict cleared");
        settle_chk(S_TX, N_ON, "R9 restart after conflict");
        tx_bit = 1'b0;
        step();
        expect_now(S_CFG, 1'b0, 1'b0, 1'b0, "R4 leave transmit");
        settle_chk(S_CFG, N_OFF, "R9 leave transmit window");

        // Fuse entry attempts
        key_val = 4'hF; key_wr = 1'b1; fuse_arm = 1'b0;
        step();
        key_wr = 1'b0;
        expect_now(S_CFG, 1'b1, 1'b0, 1'b0, "R6 unarmed key ignored");
        fuse_arm = 1'b1; key_val = 4'h5; key_wr = 1'b1;
        step();
        key_wr = 1'b0;
        expect_now(S_CFG, 1'b1, 1'b0, 1'b0, "R6 wrong key ignored");
        key_val = 4'hF; key_wr = 1'b1;
        step();
        key_wr = 1'b0;
        expect_now(S_FUSE, 1'b0, 1'b0, 1'b0, "R6 R8 enter fuse isolated");
        settle_chk(S_FUSE, N_FUSE, "R9 fuse entry window");

        // Inside fuse
        rx_pin = 1'b1; tx_pin = 1'b0;
        step();
        expect_now(S_FUSE, 1'b1, 1'b0, 1'b0, "R7 request ignored in fuse");
        rx_pin = 1'b0; key_val = 4'h3; key_wr = 1'b1;
        step();
        key_wr = 1'b0;
        expect_now(S_FUSE, 1'b1, 1'b0, 1'b0, "R7 other key ignored in fuse");
        key_val = 4'h0; key_wr = 1'b1;
        step();
        key_wr = 1'b0; fuse_arm = 1'b0;
        expect_now(S_CFG, 1'b0, 1'b0, 1'b0, "R7 exit fuse");
        settle_chk(S_CFG, N_FUSE, "R9 fuse exit window");

        // Key during receive is ignored
        rx_bit = 1'b1; ant_sel = 1'b1;
        step();
        expect_now(S_RX, 1'b0, 1'b0, 1'b0, "R4 receive via bit");
        fuse_arm = 1'b1; key_val = 4'hF; key_wr = 1'b1;
        step();
        key_wr = 1'b0; fuse_arm = 1'b0;
        expect_now(S_RX, 1'b0, 1'b0, 1'b0, "R6 key ignored in receive");

        // Forced off from receive
        pwr_on = 1'b0;
        step();
        expect_now(S_OFF, 1'b0, 1'b0, 1'b0, "R2 forced off from receive");
        settle_chk(S_OFF, N_SLP, "R9 sleep window");

        // Wake again
        rx_bit = 1'b0;
        pwr_on = 1'b1;
        step();
        expect_now(S_CFG, 1'b0, 1'b1, 1'b0, "R3 second wake pulse");
        step();
        expect_now(S_CFG, 1'b0, 1'b0, 1'b0, "R3 pulse is one cycle");

        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule